// File: doc/BRIEF.md
# Posted-Write Peripheral Bridge

This block connects a fast processor-side register port to a slower two-phase peripheral bus. It holds one posted write. A write that finds the buffer empty is acknowledged in the same cycle that the processor presents it. The buffered address and data are then transferred to the peripheral at the slower rate, which a clock-enable strobe sets. While that write is outstanding, the bridge raises a pending flag.

Reads are never posted. A read stays stalled until the buffered write has finished on the peripheral side. It then runs its own peripheral transfer and only afterwards acknowledges with the returned data. Software can therefore issue a read to the same peripheral to be sure that an earlier register write, for example clearing an interrupt flag, has really landed. A second write that arrives while the buffer is full is stalled until the first write drains.

Top module: `posted_write_bridge`

## Requirements
- R1: While reset is held and right after it, `wr_pending`, `per_sel` and `per_en` are 0, and `cpu_ready` is 1 for a write request.
- R2: A write presented while `wr_pending` is 0 sees `cpu_ready` high combinationally in the same cycle, so it is accepted at the next clock edge without waiting for any peripheral tick.
- R3: After a write is accepted, `wr_pending` is 1 and the peripheral location still holds its old value. The acknowledge therefore comes before the peripheral update.
- R4: A buffered write takes one setup phase (`per_sel`=1, `per_en`=0) and one access phase (`per_sel`=1, `per_en`=1), each lasting until the next tick. The write is performed at the tick edge that ends the access phase. That edge is the third tick edge after acceptance, and `wr_pending` falls at the same edge.
- R5: A write presented while `wr_pending` is 1 keeps `cpu_ready` low. It becomes ready once the first write has drained, three tick edges after the first write was accepted.
- R6: A read issued directly behind a write waits for that write to drain, then runs its own setup and access phases. It is acknowledged six tick edges after the write was accepted, with the data just written.
- R7: A read with no write pending is acknowledged three tick edges after it is presented. `cpu_rdata` carries the value the peripheral returned in the access phase.
- R8: `per_sel` and `per_en` change only at clock edges where `per_tick` is 1. `per_en` is never high without `per_sel`, and every access phase directly follows a setup phase.
- R9: During a write transfer, `per_wr` is 1 and `per_addr`/`per_wdata` equal the address and data that were accepted. The addressed peripheral location then holds exactly that data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| per_tick | input | 1 | Clock enable marking one peripheral-rate step |
| cpu_valid | input | 1 | Processor request present |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes at the next edge when high together with cpu_valid |
| cpu_rdata | output | DATA_W | Read data, valid while a read sees cpu_ready |
| wr_pending | output | 1 | A posted write has not yet reached the peripheral |
| per_sel | output | 1 | Peripheral select (setup and access phases) |
| per_en | output | 1 | Peripheral access phase strobe |
| per_wr | output | 1 | Peripheral transfer direction, 1 = write |
| per_addr | output | ADDR_W | Peripheral address |
| per_wdata | output | DATA_W | Peripheral write data |
| per_rdata | input | DATA_W | Peripheral read data, sampled at the end of the access phase |

## Verification
Every latency is counted in tick edges, not in clock cycles. A write acknowledge is due with zero ticks of waiting. Its peripheral update and the fall of the pending flag are due three tick edges after acceptance. A stalled write becomes ready at three, a lone read at three, and a read behind a write at six. The bench keeps a running count of clock edges taken with the tick high. It samples each result half a cycle after the edge that should produce it and compares the difference in counts with these figures. It sweeps tick periods of 1 to 4 cycles over all 16 peripheral locations, so any slip of one phase shows up as a wrong count.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } pwb_phase_e;
endpackage

// File: rtl/pwb_rstsync.sv
module pwb_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pwb_wbuf.sv
module pwb_wbuf #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              drain,
  output logic              full,
  output logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_data
);
  logic              full_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    full_d = full;
    addr_d = b_addr;
    data_d = b_data;
    if (drain) full_d = 1'b0;
    if (load) begin
      full_d = 1'b1;
      addr_d = ld_addr;
      data_d = ld_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      b_addr <= '0;
      b_data <= '0;
    end else begin
      full   <= full_d;
      b_addr <= addr_d;
      b_data <= data_d;
    end
  end
endmodule

// File: rtl/pwb_pseq.sv
module pwb_pseq
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_job,
  input  logic              rd_job,
  input  logic [ADDR_W-1:0] rd_addr_in,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_data,
  input  logic [DATA_W-1:0] per_rdata,
  output logic              per_sel,
  output logic              per_en,
  output logic              per_wr,
  output logic [ADDR_W-1:0] per_addr,
  output logic [DATA_W-1:0] per_wdata,
  output logic              wr_done,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data
);
  pwb_phase_e        phase_q, phase_d;
  logic              opwr_q, opwr_d;
  logic [ADDR_W-1:0] raddr_q, raddr_d;
  logic              rdone_d;
  logic [DATA_W-1:0] rdata_d;
  logic              finish;

  assign finish  = tick && (phase_q == PH_ACCESS);
  assign wr_done = finish && opwr_q;

  always_comb begin
    phase_d = phase_q;
    opwr_d  = opwr_q;
    raddr_d = raddr_q;
    rdone_d = 1'b0;
    rdata_d = rd_data;
    if (tick) begin
      unique case (phase_q)
        PH_IDLE: begin
          if (wr_job) begin
            phase_d = PH_SETUP;
            opwr_d  = 1'b1;
          end else if (rd_job) begin
            phase_d = PH_SETUP;
            opwr_d  = 1'b0;
            raddr_d = rd_addr_in;
          end
        end
        PH_SETUP:  phase_d = PH_ACCESS;
        PH_ACCESS: begin
          phase_d = PH_IDLE;
          if (!opwr_q) begin
            rdone_d = 1'b1;
            rdata_d = per_rdata;
          end
        end
        default:   phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      opwr_q  <= 1'b0;
      raddr_q <= '0;
      rd_done <= 1'b0;
      rd_data <= '0;
    end else begin
      phase_q <= phase_d;
      opwr_q  <= opwr_d;
      raddr_q <= raddr_d;
      rd_done <= rdone_d;
      rd_data <= rdata_d;
    end
  end

  assign per_sel   = (phase_q != PH_IDLE);
  assign per_en    = (phase_q == PH_ACCESS);
  assign per_wr    = per_sel && opwr_q;
  assign per_addr  = opwr_q ? b_addr : raddr_q;
  assign per_wdata = b_data;
endmodule

// File: rtl/posted_write_bridge.sv
module posted_write_bridge #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              per_tick,
  input  logic              cpu_valid,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              wr_pending,
  output logic              per_sel,
  output logic              per_en,
  output logic              per_wr,
  output logic [ADDR_W-1:0] per_addr,
  output logic [DATA_W-1:0] per_wdata,
  input  logic [DATA_W-1:0] per_rdata
);
  logic              rst_n_i;
  logic              buf_load;
  logic              buf_drain;
  logic [ADDR_W-1:0] buf_addr;
  logic [DATA_W-1:0] buf_data;
  logic              rd_req;
  logic              rd_done;

  pwb_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  // posted write: taken whenever the single slot is free
  assign buf_load = cpu_valid && cpu_wr && !wr_pending;
  // read: offered to the sequencer until its completion pulse
  assign rd_req   = cpu_valid && !cpu_wr && !rd_done;

  pwb_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wbuf (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .load    (buf_load),
    .ld_addr (cpu_addr),
    .ld_data (cpu_wdata),
    .drain   (buf_drain),
    .full    (wr_pending),
    .b_addr  (buf_addr),
    .b_data  (buf_data)
  );

  pwb_pseq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pseq (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .tick       (per_tick),
    .wr_job     (wr_pending),
    .rd_job     (rd_req),
    .rd_addr_in (cpu_addr),
    .b_addr     (buf_addr),
    .b_data     (buf_data),
    .per_rdata  (per_rdata),
    .per_sel    (per_sel),
    .per_en     (per_en),
    .per_wr     (per_wr),
    .per_addr   (per_addr),
    .per_wdata  (per_wdata),
    .wr_done    (buf_drain),
    .rd_done    (rd_done),
    .rd_data    (cpu_rdata)
  );

  assign cpu_ready = cpu_wr ? !wr_pending : rd_done;
endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              per_tick,
  input logic              cpu_valid,
  input logic              cpu_wr,
  input logic              cpu_ready,
  input logic              wr_pending,
  input logic              per_sel,
  input logic              per_en,
  input logic              per_wr,
  input logic [ADDR_W-1:0] per_addr
);
  // R8
  en_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_en |-> per_sel);

  // R8
  setup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per_en) |-> $past(per_sel && !per_en));

  // R8
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(per_tick) |-> $stable({per_sel, per_en}));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(per_sel && !per_tick) |-> $stable(per_addr) && $stable(per_wr));

  // R5
  wr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_wr && cpu_ready) |-> !wr_pending);

  // R6
  rd_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_wr && cpu_ready) |-> !wr_pending);

  // R4
  drain_on_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_pending) |-> $past(per_tick && per_en && per_wr));

  // R3
  pend_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_wr && cpu_ready) |=> wr_pending);
endmodule

bind posted_write_bridge pwb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .per_tick   (per_tick),
  .cpu_valid  (cpu_valid),
  .cpu_wr     (cpu_wr),
  .cpu_ready  (cpu_ready),
  .wr_pending (wr_pending),
  .per_sel    (per_sel),
  .per_en     (per_en),
  .per_wr     (per_wr),
  .per_addr   (per_addr)
);

// File: tb/posted_write_bridge_test.sv
`timescale 1ns/1ps
module posted_write_bridge_test;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          tick;
  logic          cv, cw;
  logic [AW-1:0] ca;
  logic [DW-1:0] cd;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          wr_pending;
  logic          per_sel, per_en, per_wr;
  logic [AW-1:0] per_addr;
  logic [DW-1:0] per_wdata, per_rdata;

  logic [DW-1:0] mem [16];
  int            period;
  int            tick_edges;
  int            n_chk, n_fail;
  logic          prev_tick_edge;
  logic [1:0]    prev_phase;

  posted_write_bridge #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .per_tick(tick),
    .cpu_valid(cv), .cpu_wr(cw), .cpu_addr(ca), .cpu_wdata(cd),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .wr_pending(wr_pending),
    .per_sel(per_sel), .per_en(per_en), .per_wr(per_wr),
    .per_addr(per_addr), .per_wdata(per_wdata), .per_rdata(per_rdata)
  );

  assign per_rdata = mem[per_addr[3:0]];

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  // tick generator, driven away from the active edge
  initial begin
    int cnt;
    cnt = 0;
    tick = 1'b0;
    forever begin
      @(negedge clk);
      cnt = (cnt + 1 >= period) ? 0 : cnt + 1;
      tick = (cnt == 0);
    end
  end

  // tick edge counter and peripheral model
  initial begin
    tick_edges = 0;
    prev_tick_edge = 1'b1;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    forever begin
      @(posedge clk);
      prev_tick_edge = tick;
      if (tick) tick_edges = tick_edges + 1;
      if (rst_n && tick && per_sel && per_en && per_wr)
        mem[per_addr[3:0]] <= per_wdata;
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R8 monitor: phase outputs move only across tick edges
  initial begin
    prev_phase = 2'b00;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!prev_tick_edge)
          check("R8 phase moved without tick", {30'd0, per_sel, per_en}, {30'd0, prev_phase});
        if (per_en && !per_sel) check("R8 en without sel", 32'd1, 32'd0);
      end
      prev_phase = {per_sel, per_en};
    end
  end

  task automatic cpu_op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output int waited, output logic [DW-1:0] rd);
    int base;
    @(negedge clk);
    cv = 1'b1; cw = w; ca = a; cd = d;
    base = tick_edges;
    #2;
    while (!cpu_ready) begin
      @(negedge clk);
      #2;
    end
    waited = tick_edges - base;
    rd = cpu_rdata;
    @(posedge clk);
    #1;
    cv = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int p);
    return (a * 32'h0101_0101) ^ (p << 20) ^ 32'h0000_00A5;
  endfunction

  initial begin
    int w, base;
    logic [DW-1:0] r;
    n_chk = 0; n_fail = 0;
    period = 1;
    cv = 1'b0; cw = 1'b1; ca = '0; cd = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 pending in reset", {31'd0, wr_pending}, 32'd0);
    check("R1 sel in reset", {31'd0, per_sel}, 32'd0);
    check("R1 en in reset", {31'd0, per_en}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ready after reset", {31'd0, cpu_ready}, 32'd1);
    check("R1 pending after reset", {31'd0, wr_pending}, 32'd0);

    for (int p = 1; p <= 4; p++) begin
      period = p;
      repeat (5) @(negedge clk);
      for (int a = 0; a < 16; a++) begin
        cpu_op(1'b1, AW'(a), pat(a, p), w, r);
        base = tick_edges;
        check("R2 write ack wait", w, 0);
        check("R3 pending after ack", {31'd0, wr_pending}, 32'd1);
        check("R3 peripheral not yet written", {31'd0, mem[a] == pat(a, p)}, 32'd0);
        while (wr_pending) @(negedge clk);
        check("R4 drain ticks", tick_edges - base, 3);
        check("R9 peripheral data", mem[a], pat(a, p));
      end
      // R6: read directly behind a write
      for (int a = 0; a < 16; a += 5) begin
        cpu_op(1'b1, AW'(a), ~pat(a, p), w, r);
        cpu_op(1'b0, AW'(a), '0, w, r);
        check("R6 read-after-write ticks", w, 6);
        check("R6 read-after-write data", r, ~pat(a, p));
      end
      // R5: back-to-back writes stall
      for (int a = 1; a < 16; a += 4) begin
        cpu_op(1'b1, AW'(a), pat(a + 7, p), w, r);
        cpu_op(1'b1, AW'(a + 1), pat(a + 9, p), w, r);
        check("R5 second write wait", w, 3);
        check("R5 first write landed", mem[a], pat(a + 7, p));
        while (wr_pending) @(negedge clk);
        check("R9 second write landed", mem[a + 1], pat(a + 9, p));
      end
      // R7: lone reads
      for (int a = 0; a < 16; a += 3) begin
        cpu_op(1'b0, AW'(a), '0, w, r);
        check("R7 read ticks", w, 3);
        check("R7 read data", r, mem[a]);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule